// File: doc/BRIEF.md
# Start/Stop Interpolating Interval Meter

This block is the digital half of a time-interpolating interval counter. A start trigger and a stop trigger arrive asynchronously to the reference clock. For each trigger the block raises an error pulse at the moment of the trigger and drops it on the second rising reference-clock edge that follows. That edge is the channel's sync point, so each error pulse lasts between one and two clock periods.

An external analog stretcher turns each error pulse into an expanded pulse that is a fixed ratio longer. The block measures each expanded pulse by counting reference-clock cycles, but only after its own channel has reached its sync point. It also counts the clock edges between the start sync point and the stop sync point. When both expanded pulses have ended, it combines the coarse count and the two fine counts into one interval in picoseconds. It then raises a single strobe, and both channels rearm.

One fine count unit is CLK_PS / EXP_RATIO picoseconds. A fine count outside the window that the one-to-two-period bound allows, widened by a tolerance, raises an error flag.

Top module: `tdc_interval_meter`

## Requirements
- R1: When its channel is armed, a rising edge on `start_evt` or `stop_evt` raises the matching error output at once. The output falls on the second rising `clk` edge after the trigger, so its length is more than one and at most two clock periods.
- R2: `fine_start` and `fine_stop` equal the number of rising `clk` edges at which the channel's expanded input was high. Counting starts only after that channel's sync point, and expanded-input activity before the sync point has no effect.
- R3: `coarse_cnt` equals the number of `clk` edges from the start sync edge to the stop sync edge. Because the stop channel arms only after the start sync point has been seen, the count is never below 3.
- R4: `interval_ps` = `coarse_cnt`·CLK_PS + `fine_start`·LSB − `fine_stop`·LSB, where LSB = CLK_PS / EXP_RATIO.
- R5: `result_valid` is high for exactly one cycle per measurement, and only after both expanded pulses have ended. All result outputs change only at that strobe and hold their values until the next one.
- R6: `range_err` is 1 when either fine count is below EXP_RATIO − FINE_TOL or above 2·EXP_RATIO + FINE_TOL. It is 0 when both counts lie within those bounds, including the bounds themselves.
- R7: A fine counter saturates at 2^FINE_W − 1 and never wraps.
- R8: A stop trigger that arrives before the start sync point has been taken is ignored. `stop_err` stays low and the later measurement is unaffected.
- R9: After each strobe both channels rearm. Each new measurement produces exactly one start error pulse and is independent of the previous one.
- R10: While `rst_n` is low, all outputs are 0 and triggers produce no error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | 1 | Asynchronous start trigger (rising edge) |
| stop_evt | input | 1 | Asynchronous stop trigger (rising edge) |
| start_exp | input | 1 | Expanded start error pulse from the stretcher |
| stop_exp | input | 1 | Expanded stop error pulse from the stretcher |
| start_err | output | 1 | Start error pulse to the stretcher |
| stop_err | output | 1 | Stop error pulse to the stretcher |
| result_valid | output | 1 | One-cycle strobe: a new result is on the outputs |
| interval_ps | output | RES_W | Measured interval in picoseconds |
| coarse_cnt | output | COARSE_W | Clock edges between the two sync points |
| fine_start | output | FINE_W | Expanded start pulse length in clock cycles |
| fine_stop | output | FINE_W | Expanded stop pulse length in clock cycles |
| range_err | output | 1 | A fine count lies outside its allowed window |

## Verification
The bench drives trigger pairs with phase offsets from 25 ps up to just under a full period. Extreme offsets in opposite directions separate a sign error in the fine correction from a swap of the two channels. A minimum gap of three edges tests the coarse count at its floor, and long gaps test it away from that floor.

The expanded pulses come from a bench stretcher model. Forced lengths place the counts exactly on each window bound and one count past it, and one very long pulse reaches saturation. Further stimuli are an early stop trigger, expanded-input activity before sync, and triggers during reset. Each of these tells a correctly gated channel apart from one that accepts input it should ignore.

// File: rtl/tdc_pkg.sv
`timescale 1ps/1ps
package tdc_pkg;
    localparam int N_CH     = 2;
    localparam int CH_START = 0;
    localparam int CH_STOP  = 1;

    typedef enum logic [1:0] {
        ST_WAIT_START = 2'd0,
        ST_RUN        = 2'd1,
        ST_WAIT_FINE  = 2'd2,
        ST_REPORT     = 2'd3
    } meas_state_e;
endpackage

// File: rtl/tdc_err_gen.sv
`timescale 1ps/1ps
// Error pulse generator for one channel: an armed trigger sets a capture
// flop at once; two clock stages then define the sync edge that ends it.
module tdc_err_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic evt,
    output logic err_pulse,
    output logic sync
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t q, d;
    logic  aclr;
    logic  hit_q;

    assign aclr = clr | ~rst_n;

    // Capture flop clocked by the trigger itself (asynchronous to clk).
    always_ff @(posedge evt or posedge aclr) begin
        if (aclr) begin
            hit_q <= 1'b0;
        end else if (arm) begin
            hit_q <= 1'b1;
        end
    end

    always_comb begin
        d.s1 = hit_q & ~clr;
        d.s2 = q.s1 & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign err_pulse = hit_q & ~q.s2;
    assign sync      = q.s2;

    // R1: pulse is seen high at no more than two consecutive edges
    p_err_two_edges_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && $past(err_pulse)) |=> !err_pulse);
endmodule

// File: rtl/tdc_fine_cnt.sv
`timescale 1ps/1ps
// Fine counter: counts clock cycles of the expanded pulse once enabled.
module tdc_fine_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         exp_in,
    output logic [W-1:0] cnt,
    output logic         done
);
    localparam logic [W-1:0] CNT_SAT = '1;

    typedef struct packed {
        logic         exp_s;
        logic         seen;
        logic         done;
        logic [W-1:0] cnt;
    } fine_t;

    fine_t q, d;

    always_comb begin
        d       = q;
        d.exp_s = exp_in;
        if (clr) begin
            d.seen = 1'b0;
            d.done = 1'b0;
            d.cnt  = '0;
        end else if (en && !q.done) begin
            if (q.exp_s) begin
                d.seen = 1'b1;
                if (q.cnt != CNT_SAT) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (q.seen) begin
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt  = q.cnt;
    assign done = q.done;

    // R7: count never decreases unless cleared (no wrap)
    p_fine_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (cnt >= $past(cnt)));
    // R2: no counting while the channel has not synced
    p_fine_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/tdc_interval_meter.sv
`timescale 1ps/1ps
module tdc_interval_meter
    import tdc_pkg::*;
#(
    parameter int CLK_PS    = 10000,
    parameter int EXP_RATIO = 400,
    parameter int FINE_TOL  = 8,
    parameter int COARSE_W  = 16,
    parameter int RES_W     = 32,
    parameter int FINE_W    = $clog2(2*EXP_RATIO + FINE_TOL + 1) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_evt,
    input  logic                stop_evt,
    input  logic                start_exp,
    input  logic                stop_exp,
    output logic                start_err,
    output logic                stop_err,
    output logic                result_valid,
    output logic [RES_W-1:0]    interval_ps,
    output logic [COARSE_W-1:0] coarse_cnt,
    output logic [FINE_W-1:0]   fine_start,
    output logic [FINE_W-1:0]   fine_stop,
    output logic                range_err
);
    localparam int LSB_PS   = CLK_PS / EXP_RATIO;
    localparam int FINE_MIN = EXP_RATIO - FINE_TOL;
    localparam int FINE_MAX = 2*EXP_RATIO + FINE_TOL;

    localparam logic [RES_W-1:0]    CLK_W   = RES_W'(CLK_PS);
    localparam logic [RES_W-1:0]    LSB_W   = RES_W'(LSB_PS);
    localparam logic [FINE_W-1:0]   MIN_F   = FINE_W'(FINE_MIN);
    localparam logic [FINE_W-1:0]   MAX_F   = FINE_W'(FINE_MAX);
    localparam logic [COARSE_W-1:0] CRS_SAT = '1;

    typedef struct packed {
        meas_state_e         st;
        logic [COARSE_W-1:0] coarse;
        logic                clr;
        logic                vld;
        logic [RES_W-1:0]    ival;
        logic [COARSE_W-1:0] crs_out;
        logic [FINE_W-1:0]   fs;
        logic [FINE_W-1:0]   fp;
        logic                rerr;
    } meas_t;

    meas_t q, d;

    logic [N_CH-1:0]   evt_v, exp_v, arm_v, err_v, sync_v, done_v;
    logic [FINE_W-1:0] cnt_v [N_CH];
    logic [RES_W-1:0]  ival_calc;
    logic              rerr_calc;

    assign evt_v[CH_START] = start_evt;
    assign evt_v[CH_STOP]  = stop_evt;
    assign exp_v[CH_START] = start_exp;
    assign exp_v[CH_STOP]  = stop_exp;
    assign arm_v[CH_START] = (q.st == ST_WAIT_START);
    assign arm_v[CH_STOP]  = (q.st == ST_RUN);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tdc_err_gen u_err (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (q.clr),
            .arm       (arm_v[c]),
            .evt       (evt_v[c]),
            .err_pulse (err_v[c]),
            .sync      (sync_v[c])
        );
        tdc_fine_cnt #(.W(FINE_W)) u_fine (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (q.clr),
            .en     (sync_v[c]),
            .exp_in (exp_v[c]),
            .cnt    (cnt_v[c]),
            .done   (done_v[c])
        );
    end

    always_comb begin
        ival_calc = RES_W'(q.coarse) * CLK_W
                  + RES_W'(cnt_v[CH_START]) * LSB_W
                  - RES_W'(cnt_v[CH_STOP]) * LSB_W;
        rerr_calc = (cnt_v[CH_START] < MIN_F) || (cnt_v[CH_START] > MAX_F)
                 || (cnt_v[CH_STOP]  < MIN_F) || (cnt_v[CH_STOP]  > MAX_F);
    end

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        d.clr = 1'b0;
        unique case (q.st)
            ST_WAIT_START: begin
                if (sync_v[CH_START]) begin
                    d.st     = ST_RUN;
                    d.coarse = COARSE_W'(1);
                end
            end
            ST_RUN: begin
                if (sync_v[CH_STOP]) begin
                    d.st = ST_WAIT_FINE;
                end else if (q.coarse != CRS_SAT) begin
                    d.coarse = q.coarse + 1'b1;
                end
            end
            ST_WAIT_FINE: begin
                if (&done_v) begin
                    d.st      = ST_REPORT;
                    d.vld     = 1'b1;
                    d.clr     = 1'b1;
                    d.ival    = ival_calc;
                    d.crs_out = q.coarse;
                    d.fs      = cnt_v[CH_START];
                    d.fp      = cnt_v[CH_STOP];
                    d.rerr    = rerr_calc;
                end
            end
            default: begin
                d.st = ST_WAIT_START;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_WAIT_START;
        end else begin
            q <= d;
        end
    end

    assign start_err    = err_v[CH_START];
    assign stop_err     = err_v[CH_STOP];
    assign result_valid = q.vld;
    assign interval_ps  = q.ival;
    assign coarse_cnt   = q.crs_out;
    assign fine_start   = q.fs;
    assign fine_stop    = q.fp;
    assign range_err    = q.rerr;

    // R5: strobe lasts one cycle
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R5: strobe only after both fine counters finished
    p_done_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> $past(&done_v));
    // R8: stop channel never syncs without the start channel synced
    p_stop_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_v[CH_STOP] |-> sync_v[CH_START]);
    // R3: coarse count is at least three at each result
    p_coarse_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (coarse_cnt >= COARSE_W'(3)));
endmodule

// File: tb/test_tdc_interval_meter.sv
`timescale 1ps/1ps
module test_tdc_interval_meter;
    localparam int  CLK      = 5000;
    localparam int  RATIO    = 200;
    localparam int  TOL      = 8;
    localparam int  LSB      = CLK / RATIO;
    localparam int  FW       = $clog2(2*RATIO + TOL + 1) + 1;
    localparam int  SAT      = (1 << FW) - 1;
    localparam int  FMIN     = RATIO - TOL;
    localparam int  FMAX     = 2*RATIO + TOL;
    localparam int  WD_CYC   = 100000;
    localparam int  NVEC     = 6;
    // {start phase ps, gap in edges, stop phase ps}
    localparam int  VEC [NVEC][3] = '{
        '{25,   3,   4975},
        '{4975, 3,   25},
        '{2500, 10,  2500},
        '{1000, 57,  3975},
        '{3000, 120, 125},
        '{4000, 7,   4000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_evt = 1'b0, stop_evt = 1'b0;
    logic        mdl_exp_s = 1'b0, mdl_exp_p = 1'b0, pre_exp_s = 1'b0;
    logic        start_exp, stop_exp;
    logic        start_err, stop_err, result_valid, range_err;
    logic [31:0] interval_ps;
    logic [15:0] coarse_cnt;
    logic [FW-1:0] fine_start, fine_stop;

    int     checks = 0, failures = 0, strobes = 0, runs = 0;
    int     s_rises = 0, p_rises = 0;
    int     force_s = 0, force_p = 0;
    longint len_s = 0, len_p = 0;

    assign start_exp = mdl_exp_s | pre_exp_s;
    assign stop_exp  = mdl_exp_p;

    always #(CLK/2) clk = ~clk;

    tdc_interval_meter #(
        .CLK_PS(CLK), .EXP_RATIO(RATIO), .FINE_TOL(TOL)
    ) i_tdc_interval_meter (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .start_exp(start_exp), .stop_exp(stop_exp), .start_err(start_err),
        .stop_err(stop_err), .result_valid(result_valid),
        .interval_ps(interval_ps), .coarse_cnt(coarse_cnt),
        .fine_start(fine_start), .fine_stop(fine_stop), .range_err(range_err)
    );

    // Stretcher model, start channel
    initial begin
        longint t0, dly;
        forever begin
            @(posedge start_err);
            s_rises++;
            t0 = $time;
            @(negedge start_err);
            len_s = $time - t0;
            #1000;
            mdl_exp_s = 1'b1;
            dly = (force_s > 0) ? longint'(force_s) * CLK : len_s * RATIO;
            #(dly);
            mdl_exp_s = 1'b0;
        end
    end

    // Stretcher model, stop channel
    initial begin
        longint t0, dly;
        forever begin
            @(posedge stop_err);
            p_rises++;
            t0 = $time;
            @(negedge stop_err);
            len_p = $time - t0;
            #1000;
            mdl_exp_p = 1'b1;
            dly = (force_p > 0) ? longint'(force_p) * CLK : len_p * RATIO;
            #(dly);
            mdl_exp_p = 1'b0;
        end
    end

    initial begin
        forever begin
            @(posedge result_valid);
            strobes++;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(longint'(WD_CYC) * CLK);
        failures++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", runs, runs + 1);
        summary();
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_meas(input int off1, input int gap, input int off2,
                            input int fs_force, input int fp_force);
        int fs_e, fp_e, s0, waited;
        longint ival_e;
        logic rerr_e;
        force_s = fs_force;
        force_p = fp_force;
        s0 = s_rises;
        fs_e = (fs_force > 0) ? ((fs_force > SAT) ? SAT : fs_force) : (2*CLK - off1) / LSB;
        fp_e = (fp_force > 0) ? ((fp_force > SAT) ? SAT : fp_force) : (2*CLK - off2) / LSB;
        ival_e = longint'(gap) * CLK + longint'(fs_e) * LSB - longint'(fp_e) * LSB;
        rerr_e = (fs_e < FMIN) || (fs_e > FMAX) || (fp_e < FMIN) || (fp_e > FMAX);
        @(posedge clk);
        #(off1);
        start_evt = 1'b1;
        start_evt <= #500 1'b0;
        repeat (gap) @(posedge clk);
        #(off2);
        stop_evt = 1'b1;
        stop_evt <= #500 1'b0;
        waited = 0;
        do begin
            @(negedge clk);
            waited++;
        end while (!result_valid && waited < 6000);
        runs++;
        chk("R5 strobe seen", result_valid, 1);
        chk("R5 expanded pulses ended", {start_exp, stop_exp}, 0);
        chk("R1 start error pulse length", len_s, 2*CLK - off1);
        chk("R1 stop error pulse length", len_p, 2*CLK - off2);
        chk("R3 coarse count", coarse_cnt, gap);
        chk("R2 fine start", fine_start, fs_e);
        chk("R2 fine stop", fine_stop, fp_e);
        chk("R4 interval", interval_ps, ival_e);
        chk("R6 range flag", range_err, rerr_e);
        chk("R9 one start pulse per measurement", s_rises - s0, 1);
        force_s = 0;
        force_p = 0;
    endtask

    initial begin
        // R10: reset state and triggers ignored during reset
        repeat (2) @(negedge clk);
        start_evt = 1'b1;
        stop_evt  = 1'b1;
        #500;
        start_evt = 1'b0;
        stop_evt  = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset error outputs", {start_err, stop_err}, 0);
        chk("R10 reset result outputs",
            {result_valid, range_err, |interval_ps, |coarse_cnt, |fine_start, |fine_stop}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 no pulse from trigger in reset", s_rises + p_rises, 0);

        // R8: early stop trigger ignored
        #700;
        stop_evt = 1'b1;
        #500;
        stop_evt = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 early stop produces no pulse", p_rises, 0);

        // R2: expanded-input activity before sync is ignored
        pre_exp_s = 1'b1;
        repeat (30) @(negedge clk);
        pre_exp_s = 1'b0;
        repeat (3) @(negedge clk);

        // Main vector table (R1-R4, R9 rearm across back-to-back runs)
        for (int i = 0; i < NVEC; i++) begin
            run_meas(VEC[i][0], VEC[i][1], VEC[i][2], 0, 0);
        end
        chk("R8 one stop pulse per accepted measurement", p_rises, NVEC);

        // R5: results held after the strobe
        begin
            logic [31:0] held;
            held = interval_ps;
            repeat (3) @(negedge clk);
            chk("R5 result held", interval_ps, held);
            chk("R5 strobe single cycle", result_valid, 0);
        end

        // R6: window bounds
        run_meas(1000, 20, 1000, 150, 0);
        run_meas(1000, 20, 1000, FMIN, FMAX);
        run_meas(1000, 20, 1000, FMIN - 1, 0);
        run_meas(1000, 20, 1000, 0, FMAX + 1);
        // R7: saturation
        run_meas(1000, 20, 1000, SAT + 500, 0);

        chk("R5 strobes equal measurements", strobes, runs);
        summary();
        $finish;
    end
endmodule